// File: doc/BRIEF.md
# Protected Word Memory Access Controller

This block sits behind the serial front end of a contactless tag. It takes one decoded command at a time: a 4-bit opcode, a 7-bit word address, 16 bits of write data and a 2-bit protect mask. It checks the command against the tag's word storage and against per-word one-time-programmable protection flags. It then answers with a grant or deny status and, for reads, the selected word.

The storage holds 128 words. Each word has 16 data bits, a read-protect flag and a write-protect flag. The three lowest addresses hold factory ROM words that can never be written. The top two addresses hold the configuration word and the PIN word.

A selection flag resets to 0. While it is 0 every command is answered. While it is 1, only the selection commands and the ROM read are answered, so a reader can split a population of tags into two groups. A granted write keeps the block busy for a fixed number of clock cycles, which stands in for the programming time of non-volatile storage.

Top module: `wordGuardCtrl`

## Requirements
- R1: After reset `selFlag`, `busy` and `rspValid` are 0 and `rspStatus` is 2'b00.
- R2: A command accepted on a rising edge (`cmdValid`=1, `busy`=0) is answered in the next cycle with `rspValid`=1 for one cycle. `rspStatus` is 2'b01 for grant and 2'b10 for deny. A granted Read (opcode 4'b1010) returns the stored word on `rspData`, with bit 0 being the first bit to be shifted out.
- R3: A Read of a word whose read-protect flag is set is denied, and `rspData` is 0 on every deny.
- R4: A Write (opcode 4'b1100) to a word whose write-protect flag is clear stores `cmdData` and is granted. A Write to a write-protected word is denied and leaves the word unchanged.
- R5: Addresses 0 to 2 hold the factory words set by parameter `ROM_IMAGE`, with bits [15:0] at address 0. These words are write-protected and not read-protected. A Prot command aimed at them is denied.
- R6: Prot (opcode 4'b1000) on addresses 3 to 127 is granted and ORs `cmdProt` into the word's flags. Bit 0 is read-protect and bit 1 is write-protect. A flag that has been set never clears.
- R7: A granted Write holds `busy`=1 for exactly `WRITE_CYCLES` cycles. A command presented while `busy`=1 gets no response and has no effect.
- R8: SelTag (4'b0101) sets `selFlag`, DeselTag (4'b0110) clears it and SelToggle (4'b0100) inverts it. Each of these is granted.
- R9: While `selFlag`=1, every opcode other than the three selection commands and ReadRom gets no response and changes nothing.
- R10: ReadRom (4'b0010) returns the ROM word for addresses 0 to 2 and is denied for any other address.
- R11: A Read of the PIN word at address 127 is always denied.
- R12: Add (4'b1101), Comp (4'b1110) and every opcode not listed above are denied and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Decoded opcode |
| cmdAddr | input | 7 | Word address |
| cmdData | input | 16 | Write data |
| cmdProt | input | 2 | Protect mask: bit 0 read, bit 1 write |
| rspValid | output | 1 | Response present this cycle |
| rspStatus | output | 2 | 01 grant, 10 deny, 00 idle |
| rspData | output | 16 | Read data, zero unless a read was granted |
| busy | output | 1 | Write in progress; commands are ignored |
| selFlag | output | 1 | Selection flag |

## Verification
Every address is written with an address-derived pattern and then read back. The sweep separates the normal words from the ROM words, which reject writes, and from the PIN word, which rejects reads. Protect masks that cycle through all four values are then applied to a band of addresses. The band is reread and rewritten, and a zero mask is applied afterwards, which shows whether the flags are ORed in, whether they stay sticky, and whether they gate each direction independently. All sixteen opcodes are swept once with the selection flag clear and once with it set, which separates commands that are answered, commands that are denied, and commands that are silently dropped. Commands are also injected during a write's busy window to show that they are dropped without effect.

// File: rtl/wordGuardPkg.sv
package wordGuardPkg;

  typedef enum logic [3:0] {
    OP_READ_ROM   = 4'b0010,
    OP_SEL_TOGGLE = 4'b0100,
    OP_SEL_SET    = 4'b0101,
    OP_SEL_CLEAR  = 4'b0110,
    OP_PROT       = 4'b1000,
    OP_READ       = 4'b1010,
    OP_WRITE      = 4'b1100,
    OP_ADD        = 4'b1101,
    OP_COMP       = 4'b1110
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_GRANT = 2'b01,
    ST_DENY  = 2'b10
  } status_e;

  typedef struct packed {
    logic wrData;
    logic setProt;
    logic loadRsp;
    logic clrRsp;
  } strobes_t;

endpackage

// File: rtl/wordGuardStore.sv
module wordGuardStore
  import wordGuardPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 7,
  parameter int ROM_WORDS = 3,
  parameter logic [ROM_WORDS*DATA_W-1:0] ROM_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        protMask,
  output logic [DATA_W-1:0] curData,
  output logic              curRp,
  output logic              curWp,
  output logic [DATA_W-1:0] rspData
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] memData [DEPTH];
  logic              memRp   [DEPTH];
  logic              memWp   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    if (i < ROM_WORDS) begin : g_rom
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          memData[i] <= ROM_IMAGE[i*DATA_W +: DATA_W];
          memRp[i]   <= 1'b0;
          memWp[i]   <= 1'b1;
        end
      end
      a_r5_rom_locked: assert property (@(posedge clk) disable iff (!rstN)
        memWp[i] && !memRp[i] && $stable(memData[i]));
    end else begin : g_rw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          memData[i] <= '0;
          memRp[i]   <= 1'b0;
          memWp[i]   <= 1'b0;
        end else if (addr == ADDR_W'(i)) begin
          if (strb.wrData)  memData[i] <= wrData;
          if (strb.setProt) begin
            memRp[i] <= memRp[i] | protMask[0];
            memWp[i] <= memWp[i] | protMask[1];
          end
        end
      end
      a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
        ($past(memRp[i]) |-> memRp[i]) and ($past(memWp[i]) |-> memWp[i]));
      a_r4_wp_holds_data: assert property (@(posedge clk) disable iff (!rstN)
        $past(memWp[i]) |-> $stable(memData[i]));
    end
  end

  assign curData = memData[addr];
  assign curRp   = memRp[addr];
  assign curWp   = memWp[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rspData <= '0;
    else if (strb.loadRsp) rspData <= curData;
    else if (strb.clrRsp)  rspData <= '0;
  end

endmodule

// File: rtl/wordGuardFsm.sv
module wordGuardFsm
  import wordGuardPkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int ROM_WORDS    = 3,
  parameter int WRITE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              curRp,
  input  logic              curWp,
  output strobes_t          strb,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic              busy,
  output logic              selFlag
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] PIN_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ROM_TOP  = ADDR_W'(ROM_WORDS);

  logic [CNT_W-1:0] busyCnt;
  opcode_e          op;
  logic             accept, special, answer, grant, inRom;
  logic             selNext;

  assign op      = opcode_e'(cmdOp);
  assign busy    = (busyCnt != '0);
  assign accept  = cmdValid && !busy;
  assign inRom   = (cmdAddr < ROM_TOP);
  assign special = (op == OP_READ_ROM) || (op == OP_SEL_TOGGLE) ||
                   (op == OP_SEL_SET)  || (op == OP_SEL_CLEAR);
  assign answer  = accept && (!selFlag || special);

  always_comb begin
    grant   = 1'b0;
    selNext = selFlag;
    unique case (op)
      OP_READ_ROM:   grant = inRom;
      OP_SEL_TOGGLE: begin grant = 1'b1; selNext = !selFlag; end
      OP_SEL_SET:    begin grant = 1'b1; selNext = 1'b1;     end
      OP_SEL_CLEAR:  begin grant = 1'b1; selNext = 1'b0;     end
      OP_READ:       grant = !curRp && (cmdAddr != PIN_ADDR);
      OP_WRITE:      grant = !curWp;
      OP_PROT:       grant = !inRom;
      default:       grant = 1'b0;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.wrData  = answer && grant && (op == OP_WRITE);
    strb.setProt = answer && grant && (op == OP_PROT);
    strb.loadRsp = answer && grant && ((op == OP_READ) || (op == OP_READ_ROM));
    strb.clrRsp  = answer && !strb.loadRsp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspStatus <= ST_IDLE;
      selFlag   <= 1'b0;
      busyCnt   <= '0;
    end else begin
      rspValid  <= answer;
      rspStatus <= !answer ? ST_IDLE : (grant ? ST_GRANT : ST_DENY);
      if (answer) selFlag <= selNext;
      if (strb.wrData)  busyCnt <= CNT_W'(WRITE_CYCLES);
      else if (busy)    busyCnt <= busyCnt - 1'b1;
    end
  end

  a_r7_busy_drops_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> !rspValid);
  a_r7_write_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> busy);
  a_r9_quiet_when_selected: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && selFlag && !special) |=> (!rspValid && $stable(selFlag)));
  a_r8_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (accept && op == OP_SEL_TOGGLE) |=> (selFlag != $past(selFlag)));
  a_r2_status_valid: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == (rspStatus != ST_IDLE));

endmodule

// File: rtl/wordGuardCtrl.sv
module wordGuardCtrl
  import wordGuardPkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 7,
  parameter int ROM_WORDS    = 3,
  parameter int WRITE_CYCLES = 8,
  parameter logic [ROM_WORDS*DATA_W-1:0] ROM_IMAGE = {16'h65B7, 16'hC3A1, 16'h1234}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [1:0]        cmdProt,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [DATA_W-1:0] rspData,
  output logic              busy,
  output logic              selFlag
);

  strobes_t          strb;
  logic [DATA_W-1:0] curData;
  logic              curRp, curWp;

  wordGuardFsm #(
    .ADDR_W(ADDR_W), .ROM_WORDS(ROM_WORDS), .WRITE_CYCLES(WRITE_CYCLES)
  ) uFsm (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .curRp(curRp), .curWp(curWp), .strb(strb),
    .rspValid(rspValid), .rspStatus(rspStatus), .busy(busy), .selFlag(selFlag)
  );

  wordGuardStore #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROM_WORDS(ROM_WORDS), .ROM_IMAGE(ROM_IMAGE)
  ) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(cmdAddr), .wrData(cmdData),
    .protMask(cmdProt), .curData(curData), .curRp(curRp), .curWp(curWp),
    .rspData(rspData)
  );

  a_r3_deny_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == ST_DENY) |-> (rspData == '0));
  a_r3_idle_after_drop: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |=> $stable(rspData));

endmodule

// File: tb/tb_wordGuardCtrl.sv
module tb_wordGuardCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam logic [15:0] ROM0 = 16'h1234, ROM1 = 16'hC3A1, ROM2 = 16'h65B7;

  logic        clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [6:0]  cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic [1:0]  cmdProt = '0;
  logic        rspValid, busy, selFlag;
  logic [1:0]  rspStatus;
  logic [15:0] rspData;

  int runs = 0, fails = 0;

  logic [15:0] mData [128];
  logic        mRp [128], mWp [128];
  logic        mSel;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordGuardCtrl dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdProt(cmdProt), .rspValid(rspValid), .rspStatus(rspStatus),
    .rspData(rspData), .busy(busy), .selFlag(selFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int a);
    return 16'((a * 16'h9E37) ^ 16'h5A5A);
  endfunction

  // Reference model built from the requirements.
  task automatic model(input logic [3:0] op, input logic [6:0] a, input logic [15:0] d,
                       input logic [1:0] p, output logic v, output logic [1:0] st,
                       output logic [15:0] rd, output bit wr);
    bit special = (op == 4'b0010) || (op == 4'b0100) || (op == 4'b0101) || (op == 4'b0110);
    v = 1'b1; st = 2'b10; rd = '0; wr = 0;
    if (mSel && !special) begin v = 1'b0; st = 2'b00; return; end
    case (op)
      4'b0010: if (a < 3) begin st = 2'b01; rd = mData[a]; end
      4'b0100: begin st = 2'b01; mSel = !mSel; end
      4'b0101: begin st = 2'b01; mSel = 1'b1; end
      4'b0110: begin st = 2'b01; mSel = 1'b0; end
      4'b1010: if (a != 7'd127 && !mRp[a]) begin st = 2'b01; rd = mData[a]; end
      4'b1100: if (!mWp[a]) begin st = 2'b01; mData[a] = d; wr = 1; end
      4'b1000: if (a >= 3) begin st = 2'b01; mRp[a] |= p[0]; mWp[a] |= p[1]; end
      default: ;
    endcase
  endtask

  task automatic doCmd(input logic [3:0] op, input logic [6:0] a, input logic [15:0] d,
                       input logic [1:0] p, input string req);
    logic ev; logic [1:0] es; logic [15:0] ed; bit wr; int n;
    model(op, a, d, p, ev, es, ed, wr);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d; cmdProt = p;
    @(negedge clk);
    cmdValid = 1'b0;
    check({req, " valid"}, 32'(rspValid), 32'(ev));
    check({req, " status"}, 32'(rspStatus), 32'(es));
    if (ev) check({req, " data"}, 32'(rspData), 32'(ed));
    check("R8 selFlag", 32'(selFlag), 32'(mSel));
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R7 busy length", 32'(n), wr ? 32'(W) : 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      mData[i] = '0; mRp[i] = 1'b0; mWp[i] = (i < 3);
    end
    mData[0] = ROM0; mData[1] = ROM1; mData[2] = ROM2;
    mSel = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 selFlag", 32'(selFlag), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 rspValid", 32'(rspValid), 0);
    check("R1 rspStatus", 32'(rspStatus), 0);
    rstN = 1'b1;

    // R5 / R10: factory words through both read paths
    for (int a = 0; a < 3; a++) doCmd(4'b1010, 7'(a), '0, '0, "R5 rom read");
    for (int a = 0; a < 6; a++) doCmd(4'b0010, 7'(a), '0, '0, "R10 readrom");
    doCmd(4'b0010, 7'd127, '0, '0, "R10 readrom high");

    // R4 / R2 / R11: write every address, then read every address
    for (int a = 0; a < 128; a++) doCmd(4'b1100, 7'(a), pattern(a), '0, "R4 write sweep");
    for (int a = 0; a < 128; a++) doCmd(4'b1010, 7'(a), '0, '0,
                                       a == 127 ? "R11 pin read" : "R2 read sweep");

    // R5: prot on ROM denied, ROM unchanged
    for (int a = 0; a < 3; a++) doCmd(4'b1000, 7'(a), '0, 2'b11, "R5 rom prot");
    for (int a = 0; a < 3; a++) doCmd(4'b1010, 7'(a), '0, '0, "R5 rom after prot");

    // R6 / R3 / R4: protect band with all masks, then clear attempts
    for (int a = 3; a < 35; a++) doCmd(4'b1000, 7'(a), '0, 2'(a % 4), "R6 prot set");
    for (int a = 3; a < 35; a++) doCmd(4'b1000, 7'(a), '0, 2'b00, "R6 prot zero");
    for (int a = 3; a < 35; a++) doCmd(4'b1010, 7'(a), '0, '0, "R3 read band");
    for (int a = 3; a < 35; a++) doCmd(4'b1100, 7'(a), ~pattern(a), '0, "R4 write band");
    for (int a = 3; a < 35; a++) doCmd(4'b1010, 7'(a), '0, '0, "R3 reread band");
    doCmd(4'b1000, 7'd9, '0, 2'b10, "R6 add wp to rp word");
    doCmd(4'b1010, 7'd9, '0, '0, "R6 read after add");
    doCmd(4'b1100, 7'd9, 16'hFFFF, '0, "R6 write after add");

    // R12: all opcodes with flag clear (selection ops later restored)
    for (int o = 0; o < 16; o++) begin
      doCmd(4'(o), 7'd50, 16'hAAAA, 2'b11, "R12 opcode sweep");
      doCmd(4'b1010, 7'd50, '0, '0, "R12 state after opcode");
      doCmd(4'b0110, 7'd0, '0, '0, "R8 clear");
    end

    // R8 / R9: selected tag, all opcodes
    doCmd(4'b0101, 7'd0, '0, '0, "R8 seltag");
    for (int o = 0; o < 16; o++) begin
      if (o == 4 || o == 6) continue;
      doCmd(4'(o), 7'd60, 16'h1111, 2'b11, "R9 selected sweep");
    end
    doCmd(4'b0100, 7'd0, '0, '0, "R8 toggle off");
    doCmd(4'b1010, 7'd60, '0, '0, "R9 word untouched");
    doCmd(4'b0100, 7'd0, '0, '0, "R8 toggle on");
    doCmd(4'b0110, 7'd0, '0, '0, "R8 deseltag");

    // R7: commands during busy are dropped
    for (int k = 0; k < 2; k++) begin
      logic ev; logic [1:0] es; logic [15:0] ed; bit wr;
      model(4'b1100, 7'd70, 16'hBEEF + 16'(k), '0, ev, es, ed, wr);
      @(negedge clk);
      cmdValid = 1'b1; cmdOp = 4'b1100; cmdAddr = 7'd70; cmdData = 16'hBEEF + 16'(k);
      @(negedge clk);
      check("R7 write granted", 32'(rspStatus), 32'(es));
      cmdOp = (k == 0) ? 4'b1100 : 4'b0101; cmdAddr = 7'd71; cmdData = 16'hDEAD;
      @(negedge clk);
      cmdValid = 1'b0;
      check("R7 dropped no response", 32'(rspValid), 0);
      check("R7 dropped no sel", 32'(selFlag), 32'(mSel));
      while (busy) @(negedge clk);
      doCmd(4'b1010, 7'd71, '0, '0, "R7 dropped write absent");
      doCmd(4'b1010, 7'd70, '0, '0, "R7 real write present");
    end

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule